// File: doc/BRIEF.md
# Brain-float unbox and widen converter

This block takes a value from a 64-bit floating-point register that is meant to hold a 16-bit brain-float operand in its low half. It reads that operand and converts it to single precision. It first checks the box. Every register bit above bit 15 that the selected register width covers must be one. If any of those bits is zero, the operand is replaced by the canonical brain-float NaN (0x7fc0) before conversion.

The conversion itself is exact, so it needs no rounding. The 16 source bits become the upper half of the single-precision word and the lower half is zero. Every NaN result is turned into the canonical single-precision quiet NaN, and a signalling NaN input raises the invalid flag.

The result and flags are registered. Each conversion is started by a one-cycle enable, and its output comes back one cycle later together with a valid strobe. The reset is asynchronous and active low. It is released through a two-stage synchronizer inside the block.

Top module: `bf16w_unbox_widen`

## Requirements
- R1: With `wide_sel_i`=1, the operand is properly boxed only if `src_i[63:16]` are all ones. Otherwise the result is 0x7fc00000 and the flags are 5'b00000, whatever `src_i[15:0]` holds.
- R2: With `wide_sel_i`=0, only `src_i[31:16]` must be all ones and `src_i[63:32]` have no effect. A failed box gives 0x7fc00000 with flags 5'b00000.
- R3: For a properly boxed finite normal operand `b`, the result is `{b, 16'h0000}` and the flags are zero.
- R4: A subnormal operand (exponent field `[14:7]`=0, fraction nonzero) becomes `{b, 16'h0000}`, which is the equal single-precision subnormal, with no flush and no flags.
- R5: Infinities (0x7f80, 0xff80) and both signed zeros pass through as `{b, 16'h0000}` with flags zero.
- R6: A signalling NaN (exponent field all ones, fraction `[6:0]` nonzero, bit 6 zero) gives 0x7fc00000 and flags 5'b10000.
- R7: A quiet NaN (exponent field all ones, bit 6 one), of any sign or payload, gives 0x7fc00000 with flags zero.
- R8: The flags are ordered {invalid, divide-by-zero, overflow, underflow, inexact} from bit 4 down to bit 0. Bits 3:0 are always zero.
- R9: When `in_valid_i` is high at a rising edge, `result_o`, `flags_o` and `out_valid_o`=1 appear after that edge. When `in_valid_i` is low, `out_valid_o` drops to 0 and `result_o`/`flags_o` hold their previous values.
- R10: While `rst_n` is low, `out_valid_o`, `result_o` and `flags_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Starts a conversion (register enable) |
| wide_sel_i | input | 1 | 1: 64-bit register box check, 0: 32-bit |
| src_i | input | 64 | Floating-point register value |
| out_valid_o | output | 1 | Result strobe, one cycle after the enable |
| result_o | output | 32 | Single-precision result |
| flags_o | output | 5 | Exception flags {NV, DZ, OF, UF, NX} |

## Verification
The result, the flags and the valid strobe all come from one register stage. Each of them is therefore due exactly one rising edge after the edge that samples `in_valid_i`. The bench drives each stimulus on a falling edge and checks all three outputs on the next falling edge. For the hold case it drops the enable, changes the source, and checks one falling edge later that the result and flags have not moved. After reset is released, the bench waits out the two-edge synchronizer before it sends any stimulus.

// File: rtl/bf16w_pkg.sv
package bf16w_pkg;
  localparam int BF_W    = 16;
  localparam int SP_W    = 32;
  localparam int FLG_W   = 5;
  localparam int FLG_NV  = 4;
  localparam int BF_EXPW = 8;
  localparam int BF_FRW  = 7;

  localparam logic [BF_W-1:0] BF_CANON_NAN = 16'h7fc0;
  localparam logic [SP_W-1:0] SP_CANON_NAN = 32'h7fc0_0000;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } bf_class_t;
endpackage

// File: rtl/bf16w_rst_sync.sv
module bf16w_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bf16w_box_check.sv
module bf16w_box_check
  import bf16w_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [FLEN-1:0] src_i,
  input  logic            wide_sel_i,
  output logic [BF_W-1:0] op_o,
  output logic            boxed_o
);
  localparam int NARROW_HI = SP_W - 1;

  logic narrow_ok;
  logic upper_ok;

  assign narrow_ok = &src_i[NARROW_HI:BF_W];

  generate
    if (FLEN > SP_W) begin : g_upper
      assign upper_ok = &src_i[FLEN-1:SP_W];
    end else begin : g_no_upper
      assign upper_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    boxed_o = narrow_ok & (upper_ok | ~wide_sel_i);
    op_o    = boxed_o ? src_i[BF_W-1:0] : BF_CANON_NAN;
  end
endmodule

// File: rtl/bf16w_classify.sv
module bf16w_classify
  import bf16w_pkg::*;
(
  input  logic [BF_W-1:0] op_i,
  output bf_class_t       cls_o
);
  logic [BF_EXPW-1:0] expf;
  logic [BF_FRW-1:0]  frac;

  assign expf = op_i[BF_W-2 -: BF_EXPW];
  assign frac = op_i[BF_FRW-1:0];

  always_comb begin
    cls_o.is_nan  = (&expf) && (frac != '0);
    cls_o.is_snan = cls_o.is_nan && !frac[BF_FRW-1];
  end
endmodule

// File: rtl/bf16w_widen.sv
module bf16w_widen
  import bf16w_pkg::*;
(
  input  logic [BF_W-1:0]  op_i,
  input  bf_class_t        cls_i,
  output logic [SP_W-1:0]  res_o,
  output logic [FLG_W-1:0] flg_o
);
  localparam int PAD_W = SP_W - BF_W;

  always_comb begin
    res_o         = cls_i.is_nan ? SP_CANON_NAN : {op_i, {PAD_W{1'b0}}};
    flg_o         = '0;
    flg_o[FLG_NV] = cls_i.is_snan;
  end
endmodule

// File: rtl/bf16w_unbox_widen.sv
module bf16w_unbox_widen
  import bf16w_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic             wide_sel_i,
  input  logic [FLEN-1:0]  src_i,
  output logic             out_valid_o,
  output logic [SP_W-1:0]  result_o,
  output logic [FLG_W-1:0] flags_o
);
  localparam int PAD_W = SP_W - BF_W;

  logic             rst_q_n;
  logic [BF_W-1:0]  op;
  logic             boxed;
  bf_class_t        cls;
  logic [SP_W-1:0]  res_c;
  logic [FLG_W-1:0] flg_c;

  logic             vld_q, vld_d;
  logic [SP_W-1:0]  res_q, res_d;
  logic [FLG_W-1:0] flg_q, flg_d;

  bf16w_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  bf16w_box_check #(.FLEN(FLEN)) i_box (
    .src_i      (src_i),
    .wide_sel_i (wide_sel_i),
    .op_o       (op),
    .boxed_o    (boxed)
  );

  bf16w_classify i_cls (
    .op_i  (op),
    .cls_o (cls)
  );

  bf16w_widen i_widen (
    .op_i  (op),
    .cls_i (cls),
    .res_o (res_c),
    .flg_o (flg_c)
  );

  always_comb begin
    vld_d = in_valid_i;
    res_d = res_q;
    flg_d = flg_q;
    if (in_valid_i) begin
      res_d = res_c;
      flg_d = flg_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else if (!rst_q_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign out_valid_o = vld_q;
  assign result_o    = res_q;
  assign flags_o     = flg_q;

  // A failed box always leads to a quiet canonical NaN with no flags (R1/R2)
  assert_bad_box_quiet_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid_i && !boxed) |=> (result_o == SP_CANON_NAN && flags_o == '0));

  // Properly boxed non-NaN operands land in the upper half exactly (R3/R4/R5)
  assert_exact_place_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid_i && boxed && !((&src_i[BF_W-2 -: BF_EXPW]) && (src_i[BF_FRW-1:0] != '0)))
    |=> (result_o == {$past(src_i[BF_W-1:0]), {PAD_W{1'b0}}} && flags_o == '0));

  // Any NaN-shaped result must be the canonical one (R7)
  assert_nan_canonical_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid_o && (&result_o[SP_W-2 -: BF_EXPW]) && (result_o[SP_W-BF_EXPW-2:0] != '0))
    |-> (result_o == SP_CANON_NAN));

  // Invalid only accompanies the canonical NaN (R6)
  assert_nv_with_nan_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid_o && flags_o[FLG_NV]) |-> (result_o == SP_CANON_NAN));

  // No flag other than invalid can ever appear (R8)
  assert_only_nv_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    flags_o[FLG_NV-1:0] == '0);

  // Idle cycles keep the result and flags steady (R9)
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid_i |=> (!out_valid_o && $stable(result_o) && $stable(flags_o)));

  // Strobe follows the enable by one edge (R9)
  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid_i |=> out_valid_o);
endmodule

// File: tb/test_bf16w_unbox_widen.sv
module test_bf16w_unbox_widen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        wide_sel;
  logic [63:0] src;
  logic        out_valid;
  logic [31:0] result;
  logic [4:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bf16w_unbox_widen #(.FLEN(64)) i_bf16w_unbox_widen (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid),
    .wide_sel_i  (wide_sel),
    .src_i       (src),
    .out_valid_o (out_valid),
    .result_o    (result),
    .flags_o     (flags)
  );

  localparam int NV = 18;
  localparam logic        V_WIDE [NV] = '{1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,0,0,0};
  localparam logic [63:0] V_SRC  [NV] = '{
    64'hFFFF_FFFF_FFFF_3F80, 64'hFFFF_FFFF_FFFF_C049, 64'hFFFF_FFFF_FFFF_0001,
    64'hFFFF_FFFF_FFFF_807F, 64'hFFFF_FFFF_FFFF_7F80, 64'hFFFF_FFFF_FFFF_FF80,
    64'hFFFF_FFFF_FFFF_8000, 64'hFFFF_FFFF_FFFF_0000, 64'hFFFF_FFFF_FFFF_7F81,
    64'hFFFF_FFFF_FFFF_FFBF, 64'hFFFF_FFFF_FFFF_7FC0, 64'hFFFF_FFFF_FFFF_FFC5,
    64'h0000_0000_FFFF_3F80, 64'hFFFF_FFFE_FFFF_3F80, 64'hFFFF_FFFF_7FFF_7F81,
    64'h0000_0000_FFFF_3F80, 64'h1234_5678_FFFF_7F81, 64'hFFFF_FFFF_FFFE_3F80};
  localparam logic [31:0] V_RES  [NV] = '{
    32'h3F80_0000, 32'hC049_0000, 32'h0001_0000, 32'h807F_0000, 32'h7F80_0000,
    32'hFF80_0000, 32'h8000_0000, 32'h0000_0000, 32'h7FC0_0000, 32'h7FC0_0000,
    32'h7FC0_0000, 32'h7FC0_0000, 32'h7FC0_0000, 32'h7FC0_0000, 32'h7FC0_0000,
    32'h3F80_0000, 32'h7FC0_0000, 32'h7FC0_0000};
  localparam logic [4:0]  V_FLG  [NV] = '{
    5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 5'h10,
    5'h10, 5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 5'h10, 5'h00};
  localparam string       V_REQ  [NV] = '{
    "R3", "R3", "R4", "R4", "R5", "R5", "R5", "R5", "R6",
    "R6", "R7", "R7", "R1", "R1", "R1", "R2", "R2", "R2"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic w, input logic [63:0] s);
    @(negedge clk);
    wide_sel = w;
    src      = s;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    wide_sel = 1'b1;
    src      = '0;
    #12;
    // R10: outputs cleared during reset
    check("R10", {31'd0, out_valid}, 64'd0);
    check("R10", {32'd0, result}, 64'd0);
    check("R10", {59'd0, flags}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(V_WIDE[i], V_SRC[i]);
      check(V_REQ[i], {63'd0, out_valid}, 64'd1);
      check(V_REQ[i], {32'd0, result}, {32'd0, V_RES[i]});
      check(V_REQ[i], {59'd0, flags}, {59'd0, V_FLG[i]});
      // R8: bits 3:0 never set
      check("R8", {60'd0, flags[3:0]}, 64'd0);
    end

    // R9: hold while enable is low; last result was canonical NaN
    src      = 64'hFFFF_FFFF_FFFF_4040;
    wide_sel = 1'b1;
    @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd0);
    check("R9", {32'd0, result}, 64'h7FC0_0000);
    check("R9", {59'd0, flags}, 64'd0);

    // R9: strobe after an enable, then result of the new operand
    apply(1'b1, 64'hFFFF_FFFF_FFFF_4040);
    check("R9", {63'd0, out_valid}, 64'd1);
    check("R3", {32'd0, result}, 64'h4040_0000);

    // R6 then R9: invalid flag held while idle
    apply(1'b0, 64'hABCD_EF01_FFFF_FF81);
    check("R6", {59'd0, flags}, 64'h10);
    @(negedge clk);
    check("R9", {59'd0, flags}, 64'h10);
    check("R9", {32'd0, result}, 64'h7FC0_0000);

    // R10: asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    check("R10", {31'd0, out_valid}, 64'd0);
    check("R10", {32'd0, result}, 64'd0);
    check("R10", {59'd0, flags}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    apply(1'b1, 64'hFFFF_FFFF_FFFF_0040);
    check("R4", {32'd0, result}, 64'h0040_0000);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule